// File: doc/BRIEF.md
# Early Depth Mask-Plane Filter

This block sits in a rasterizer ahead of texturing and screens out pixels that are certain to be hidden. The check does not use a stored depth value. Each screen coordinate keeps a small history code in an external mask store. The code records the nearest of a few depth planes that some earlier pixel at that coordinate was in front of. A new pixel lying behind that plane cannot be visible, so its valid bit is cleared. The pixel stays in its lane of the bundle.

A bundle of four pixels arrives each cycle. Each pixel carries x, y, depth and a valid bit. The block reads the four history codes from the mask store in the same cycle, with an asynchronous read. It resolves the lanes in order and issues at most one write per coordinate. One cycle later it presents the bundle with updated valid bits and a per-pixel skip-depth-read flag. Plane positions and the mode are captured only on a frame-clear pulse. The same pulse asks the mask store to reset every code to zero.

Four modes exist:
- **One-plane:** one bit per coordinate.
- **Three-plane:** planes at centre+offset, centre and centre-offset.
- **Two-plane skip:** the farthest plane sits at the far depth, so code 0 means "never rendered". The later depth stage can then write without reading depth or color.
- **Bypass.**

Top module: `zmask_screen`

## Requirements
- R1: After reset, `out_vld` and `out_skip` are all zero, and no mask write is issued while no pixel is valid.
- R2: In mode 0 (one-plane), the plane is the centre value. A valid pixel with depth below the plane raises its coordinate's code from 0 to 1. A depth equal to or above the plane issues no write.
- R3: A valid pixel is rejected (its `out_vld` bit is 0) exactly when its coordinate's code k is nonzero and its depth is strictly greater than plane k. Other valid pixels keep valid = 1, and invalid pixels stay invalid.
- R4: In mode 1 (three-plane), plane 1 = centre+offset saturated at the all-ones depth, plane 2 = centre, and plane 3 = centre-offset saturated at 0. The code becomes the highest plane index whose position is strictly greater than the pixel's depth.
- R5: A code is only ever raised. Every write carries a value greater than the code read for that coordinate.
- R6: In mode 2 (two-plane skip), plane 1 is the all-ones far depth and every valid pixel counts as in front of it. Planes 2 and 3 are centre and centre-offset. A passing pixel whose code was 0 has `out_skip` set.
- R7: Pixels in one bundle that share a coordinate are resolved in lane order from lane 0 upward, with each lane seeing the earlier lanes' updates. Only the last valid lane at a coordinate writes it.
- R8: Mode, centre and offset load only in a cycle with `frame_clear` high. That cycle drives `mask_clr`, drops its pixels (`out_vld` = 0 next cycle) and issues no write.
- R9: In mode 3 (bypass), `out_vld` equals the input valid bits, `out_skip` is 0 and no write is issued.
- R10: `out_vld`, `out_skip` and the x, y and depth outputs appear one clock after the input bundle. The mask address and write strobes are valid in the input cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_clear | input | 1 | Frame boundary: load configuration, clear mask store |
| cfg_mode | input | 2 | 0 one-plane, 1 three-plane, 2 two-plane skip, 3 bypass |
| cfg_center | input | ZW | Centre plane depth |
| cfg_offset | input | ZW | Distance of the side planes from the centre |
| pix_vld | input | LANES | Per-pixel valid |
| pix_x | input | LANES*XW | Pixel x coordinates |
| pix_y | input | LANES*YW | Pixel y coordinates |
| pix_z | input | LANES*ZW | Pixel depths, all-ones = far |
| mask_addr | output | LANES*(XW+YW) | Coordinate address {y,x} per lane, for read and write |
| mask_rd_code | input | LANES*CODE_W | History code returned for each address in the same cycle |
| mask_wr_en | output | LANES | Per-lane write strobe, applied at the clock edge |
| mask_wr_code | output | LANES*CODE_W | Code to write per lane |
| mask_clr | output | 1 | Request to zero the whole mask store at the clock edge |
| out_vld | output | LANES | Screened valid bits |
| out_skip | output | LANES | Skip depth/color read for this pixel |
| out_x | output | LANES*XW | Registered x |
| out_y | output | LANES*YW | Registered y |
| out_z | output | LANES*ZW | Registered depth |

## Verification
The mask address and write strobes depend only on the current inputs and the returned codes. The store model therefore commits them at the same rising edge that registers the bundle. The valid, skip and coordinate outputs belong to the bundle driven one edge earlier. The bench drives each bundle on a falling edge and runs its reference model against its own copy of the store. At the next falling edge it compares both the outputs and the whole store with the model. A configuration change is expected to take effect only on the first bundle after the frame-clear edge.

// File: rtl/zmask_pkg.sv
package zmask_pkg;
   typedef enum logic [1:0] {
      ZM_ONE    = 2'd0,
      ZM_THREE  = 2'd1,
      ZM_SKIP   = 2'd2,
      ZM_BYPASS = 2'd3
   } zm_mode_e;
endpackage

// File: rtl/zmask_cfg.sv
module zmask_cfg
   import zmask_pkg::*;
#(
   parameter int ZW     = 8,
   parameter int CODE_W = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 frame_clear,
   input  logic [1:0]           cfg_mode,
   input  logic [ZW-1:0]        cfg_center,
   input  logic [ZW-1:0]        cfg_offset,
   output zm_mode_e             mode_eff,
   output logic [3:0][ZW-1:0]   plane
);
   localparam logic [ZW-1:0] FAR = {ZW{1'b1}};

   zm_mode_e      mode_q;
   logic [ZW-1:0] center_q, offset_q;
   logic [ZW:0]   sum;
   logic [ZW-1:0] hi, lo;

   // configuration is frame-stable: captured on the frame boundary only
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= ZM_ONE;
         center_q <= FAR;
         offset_q <= '0;
      end else if (frame_clear) begin
         mode_q   <= zm_mode_e'(cfg_mode);
         center_q <= cfg_center;
         offset_q <= cfg_offset;
      end
   end

   assign sum = {1'b0, center_q} + {1'b0, offset_q};
   assign hi  = sum[ZW] ? FAR : sum[ZW-1:0];
   assign lo  = (center_q < offset_q) ? '0 : center_q - offset_q;

   // a one-bit code can only represent the single-plane history
   generate
      if (CODE_W == 1) begin : g_one_bit
         assign mode_eff = (mode_q == ZM_BYPASS) ? ZM_BYPASS : ZM_ONE;
      end else begin : g_two_bit
         assign mode_eff = mode_q;
      end
   endgenerate

   always_comb begin
      plane[0] = FAR;
      case (mode_eff)
         ZM_THREE: begin plane[1] = hi;  plane[2] = center_q; plane[3] = lo; end
         ZM_SKIP:  begin plane[1] = FAR; plane[2] = center_q; plane[3] = lo; end
         default:  begin plane[1] = center_q; plane[2] = '0; plane[3] = '0; end
      endcase
   end
endmodule

// File: rtl/zmask_lane_chain.sv
module zmask_lane_chain
   import zmask_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int XW     = 4,
   parameter int YW     = 4,
   parameter int ZW     = 8,
   parameter int CODE_W = 2
) (
   input  zm_mode_e                          mode,
   input  logic [3:0][ZW-1:0]                plane,
   input  logic [LANES-1:0]                  vld_in,
   input  logic [LANES-1:0][XW-1:0]          x,
   input  logic [LANES-1:0][YW-1:0]          y,
   input  logic [LANES-1:0][ZW-1:0]          z,
   input  logic [LANES-1:0][CODE_W-1:0]      rd_code,
   output logic [LANES-1:0][XW+YW-1:0]       addr,
   output logic [LANES-1:0]                  vld_out,
   output logic [LANES-1:0]                  skip_out,
   output logic [LANES-1:0]                  wr_en,
   output logic [LANES-1:0][CODE_W-1:0]      wr_code
);
   always_comb begin : chain
      logic [LANES-1:0][1:0] cur;
      logic [LANES-1:0][1:0] nxt;
      logic [1:0] lvl;
      logic       rej;
      logic       bypass;
      logic       later;
      bypass = (mode == ZM_BYPASS);
      for (int i = 0; i < LANES; i++) addr[i] = {y[i], x[i]};
      // lanes resolve in order; a later lane sees an earlier lane's new code
      for (int i = 0; i < LANES; i++) begin
         cur[i] = 2'(rd_code[i]);
         for (int j = 0; j < i; j++)
            if (vld_in[j] && addr[j] == addr[i]) cur[i] = nxt[j];
         lvl = 2'd0;
         case (mode)
            ZM_ONE:   if (z[i] < plane[1]) lvl = 2'd1;
            ZM_THREE: begin
               if (z[i] < plane[1]) lvl = 2'd1;
               if (z[i] < plane[2]) lvl = 2'd2;
               if (z[i] < plane[3]) lvl = 2'd3;
            end
            ZM_SKIP: begin
               lvl = 2'd1;
               if (z[i] < plane[2]) lvl = 2'd2;
               if (z[i] < plane[3]) lvl = 2'd3;
            end
            default: lvl = 2'd0;
         endcase
         rej         = (cur[i] != 2'd0) && (z[i] > plane[cur[i]]);
         nxt[i]      = (vld_in[i] && !bypass && lvl > cur[i]) ? lvl : cur[i];
         vld_out[i]  = vld_in[i] && (bypass || !rej);
         skip_out[i] = vld_in[i] && !rej && (mode == ZM_SKIP) && (cur[i] == 2'd0);
      end
      // only the last valid lane at a coordinate commits it
      for (int i = 0; i < LANES; i++) begin
         later = 1'b0;
         for (int j = i + 1; j < LANES; j++)
            if (vld_in[j] && addr[j] == addr[i]) later = 1'b1;
         wr_en[i]   = vld_in[i] && !bypass && !later && (nxt[i] != 2'(rd_code[i]));
         wr_code[i] = CODE_W'(nxt[i]);
      end
   end
endmodule

// File: rtl/zmask_screen.sv
module zmask_screen
   import zmask_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int XW     = 4,
   parameter int YW     = 4,
   parameter int ZW     = 8,
   parameter int CODE_W = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            frame_clear,
   input  logic [1:0]                      cfg_mode,
   input  logic [ZW-1:0]                   cfg_center,
   input  logic [ZW-1:0]                   cfg_offset,
   input  logic [LANES-1:0]                pix_vld,
   input  logic [LANES-1:0][XW-1:0]        pix_x,
   input  logic [LANES-1:0][YW-1:0]        pix_y,
   input  logic [LANES-1:0][ZW-1:0]        pix_z,
   output logic [LANES-1:0][XW+YW-1:0]     mask_addr,
   input  logic [LANES-1:0][CODE_W-1:0]    mask_rd_code,
   output logic [LANES-1:0]                mask_wr_en,
   output logic [LANES-1:0][CODE_W-1:0]    mask_wr_code,
   output logic                            mask_clr,
   output logic [LANES-1:0]                out_vld,
   output logic [LANES-1:0]                out_skip,
   output logic [LANES-1:0][XW-1:0]        out_x,
   output logic [LANES-1:0][YW-1:0]        out_y,
   output logic [LANES-1:0][ZW-1:0]        out_z
);
   generate
      if (CODE_W < 1 || CODE_W > 2) begin : g_bad_code
         $error("CODE_W must be 1 or 2");
      end
      if (LANES < 1 || XW < 1 || YW < 1 || ZW < 2) begin : g_bad_dims
         $error("LANES, XW, YW must be >= 1 and ZW >= 2");
      end
   endgenerate

   zm_mode_e                mode_eff;
   logic [3:0][ZW-1:0]      plane;
   logic [LANES-1:0]        vld_gated, vld_next, skip_next;

   assign vld_gated = frame_clear ? '0 : pix_vld;
   assign mask_clr  = frame_clear;

   zmask_cfg #(.ZW(ZW), .CODE_W(CODE_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .frame_clear(frame_clear),
      .cfg_mode(cfg_mode), .cfg_center(cfg_center), .cfg_offset(cfg_offset),
      .mode_eff(mode_eff), .plane(plane)
   );

   zmask_lane_chain #(.LANES(LANES), .XW(XW), .YW(YW), .ZW(ZW), .CODE_W(CODE_W)) u_chain (
      .mode(mode_eff), .plane(plane), .vld_in(vld_gated),
      .x(pix_x), .y(pix_y), .z(pix_z), .rd_code(mask_rd_code),
      .addr(mask_addr), .vld_out(vld_next), .skip_out(skip_next),
      .wr_en(mask_wr_en), .wr_code(mask_wr_code)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld  <= '0;
         out_skip <= '0;
         out_x    <= '0;
         out_y    <= '0;
         out_z    <= '0;
      end else begin
         out_vld  <= vld_next;
         out_skip <= skip_next;
         out_x    <= pix_x;
         out_y    <= pix_y;
         out_z    <= pix_z;
      end
   end

   a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      frame_clear |=> (out_vld == '0));
   a_r8_clear_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      frame_clear |-> (mask_wr_en == '0));
   a_r9_bypass_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_eff == ZM_BYPASS) |-> (mask_wr_en == '0));

   genvar gi, gj;
   generate
      for (gi = 0; gi < LANES; gi++) begin : g_lane_chk
         a_r3_invalid_stays: assert property (@(posedge clk) disable iff (!rst_n)
            !pix_vld[gi] |=> !out_vld[gi]);
         a_r6_skip_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
            out_skip[gi] |-> out_vld[gi]);
         a_r5_raise_only: assert property (@(posedge clk) disable iff (!rst_n)
            mask_wr_en[gi] |-> (mask_wr_code[gi] > mask_rd_code[gi]));
         for (gj = gi + 1; gj < LANES; gj++) begin : g_pair
            a_r7_one_write: assert property (@(posedge clk) disable iff (!rst_n)
               !(mask_wr_en[gi] && mask_wr_en[gj] && mask_addr[gi] == mask_addr[gj]));
         end
      end
   endgenerate
endmodule

// File: tb/tb_zmask_screen.sv
module tb_zmask_screen;
   localparam int LANES = 4, XW = 4, YW = 4, ZW = 8, CODE_W = 2, AW = XW + YW;
   localparam int NADDR = 1 << AW;

   logic clk = 1'b0, rst_n = 1'b0, frame_clear = 1'b0;
   logic [1:0] cfg_mode = 2'd0;
   logic [ZW-1:0] cfg_center = '0, cfg_offset = '0;
   logic [LANES-1:0] pix_vld = '0;
   logic [LANES-1:0][XW-1:0] pix_x = '0;
   logic [LANES-1:0][YW-1:0] pix_y = '0;
   logic [LANES-1:0][ZW-1:0] pix_z = '0;
   logic [LANES-1:0][AW-1:0] mask_addr;
   logic [LANES-1:0][CODE_W-1:0] mask_rd_code, mask_wr_code;
   logic [LANES-1:0] mask_wr_en, out_vld, out_skip;
   logic mask_clr;
   logic [LANES-1:0][XW-1:0] out_x;
   logic [LANES-1:0][YW-1:0] out_y;
   logic [LANES-1:0][ZW-1:0] out_z;

   logic [CODE_W-1:0] store [NADDR];
   logic [CODE_W-1:0] ref_st [NADDR];
   int bmode, bcen, boff;
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;

   zmask_screen #(.LANES(LANES), .XW(XW), .YW(YW), .ZW(ZW), .CODE_W(CODE_W)) dut (
      .clk(clk), .rst_n(rst_n), .frame_clear(frame_clear), .cfg_mode(cfg_mode),
      .cfg_center(cfg_center), .cfg_offset(cfg_offset), .pix_vld(pix_vld),
      .pix_x(pix_x), .pix_y(pix_y), .pix_z(pix_z), .mask_addr(mask_addr),
      .mask_rd_code(mask_rd_code), .mask_wr_en(mask_wr_en), .mask_wr_code(mask_wr_code),
      .mask_clr(mask_clr), .out_vld(out_vld), .out_skip(out_skip),
      .out_x(out_x), .out_y(out_y), .out_z(out_z)
   );

   // mask store environment: asynchronous read, writes and clear at the edge
   always_comb for (int i = 0; i < LANES; i++) mask_rd_code[i] = store[mask_addr[i]];
   always @(posedge clk) begin
      if (mask_clr) for (int a = 0; a < NADDR; a++) store[a] <= '0;
      else for (int i = 0; i < LANES; i++) if (mask_wr_en[i]) store[mask_addr[i]] <= mask_wr_code[i];
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int plane_of(int k);
      int hi, lo;
      hi = (bcen + boff > 255) ? 255 : bcen + boff;
      lo = (bcen < boff) ? 0 : bcen - boff;
      if (bmode == 0) return bcen;
      if (k == 1) return (bmode == 2) ? 255 : hi;
      if (k == 2) return bcen;
      return lo;
   endfunction

   function automatic int level_of(int z);
      int l;
      l = 0;
      if (bmode == 0) return (z < bcen) ? 1 : 0;
      if (bmode == 2 || z < plane_of(1)) l = 1;
      if (z < plane_of(2)) l = 2;
      if (z < plane_of(3)) l = 3;
      return l;
   endfunction

   // sequential lane-order reference; updates ref_st
   task automatic model(output logic [3:0] ev, output logic [3:0] es);
      for (int i = 0; i < LANES; i++) begin
         int a, cur, lvl;
         bit rej;
         a = {pix_y[i], pix_x[i]};
         cur = ref_st[a];
         ev[i] = 0; es[i] = 0;
         if (pix_vld[i]) begin
            if (bmode == 3) ev[i] = 1;
            else begin
               lvl = level_of(pix_z[i]);
               rej = (cur != 0) && (pix_z[i] > plane_of(cur));
               ev[i] = !rej;
               es[i] = !rej && bmode == 2 && cur == 0;
               if (lvl > cur) ref_st[a] = CODE_W'(lvl);
            end
         end
      end
   endtask

   task automatic cmp_store(string tag);
      int bad;
      bad = 0;
      for (int a = 0; a < NADDR; a++) if (store[a] !== ref_st[a]) bad++;
      chk(tag, bad, 0);
   endtask

   task automatic run_bundle(string tag);
      logic [3:0] ev, es;
      logic [LANES-1:0][ZW-1:0] zin;
      zin = pix_z;
      model(ev, es);
      @(posedge clk); @(negedge clk);
      chk({tag, " R3 vld"}, out_vld, ev);
      chk({tag, " R6 skip"}, out_skip, es);
      chk({tag, " R10 z"}, out_z, zin);
      cmp_store({tag, " R2 R4 R5 R7 store"});
   endtask

   task automatic do_clear(int m, int c, int o);
      cfg_mode = 2'(m); cfg_center = ZW'(c); cfg_offset = ZW'(o);
      frame_clear = 1'b1; pix_vld = 4'hF;
      @(posedge clk); @(negedge clk);
      chk("R8 clear drops", out_vld, 0);
      frame_clear = 1'b0; pix_vld = '0;
      bmode = m; bcen = c; boff = o;
      for (int a = 0; a < NADDR; a++) ref_st[a] = '0;
      cmp_store("R8 clear store");
   endtask

   task automatic set_lane(int i, bit v, int a, int z);
      pix_vld[i] = v; pix_x[i] = XW'(a); pix_y[i] = YW'(a >> XW); pix_z[i] = ZW'(z);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7));
      for (int a = 0; a < NADDR; a++) begin store[a] = '0; ref_st[a] = '0; end
      bmode = 0; bcen = 255; boff = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset vld", out_vld, 0);
      chk("R1 reset skip", out_skip, 0);
      chk("R1 no write idle", mask_wr_en, 0);

      // one-plane with a shared coordinate
      do_clear(0, 100, 0);
      set_lane(0, 1, 5, 50); set_lane(1, 1, 5, 150); set_lane(2, 1, 6, 150); set_lane(3, 1, 6, 100);
      run_bundle("R2 one-plane");
      chk("R7 lane order vld", out_vld, 4'b1101);
      chk("R2 code set", store[5], 1);
      chk("R2 equal no set", store[6], 0);

      // three-plane: planes 120, 100, 80
      do_clear(1, 100, 20);
      set_lane(0, 1, 1, 90); set_lane(1, 1, 1, 110); set_lane(2, 1, 2, 130); set_lane(3, 1, 2, 115);
      run_bundle("R4 three-plane a");
      chk("R4 vld a", out_vld, 4'b1101);
      chk("R4 code a1", store[1], 2);
      chk("R4 code a2", store[2], 1);
      set_lane(0, 1, 2, 125); set_lane(1, 1, 2, 118); set_lane(2, 1, 1, 95); set_lane(3, 1, 1, 70);
      run_bundle("R4 three-plane b");
      chk("R4 vld b", out_vld, 4'b1110);
      chk("R5 code raised", store[1], 3);

      // invalid lane stays invalid
      set_lane(0, 0, 1, 200); set_lane(1, 1, 1, 200); set_lane(2, 0, 9, 0); set_lane(3, 1, 9, 0);
      run_bundle("R3 invalid");
      chk("R3 invalid vld", out_vld, 4'b1000);

      // two-plane skip: planes far, 100, 80
      do_clear(2, 100, 20);
      set_lane(0, 1, 3, 200); set_lane(1, 1, 3, 255); set_lane(2, 1, 4, 90); set_lane(3, 1, 4, 150);
      run_bundle("R6 skip");
      chk("R6 skip vld", out_vld, 4'b0111);
      chk("R6 skip flags", out_skip, 4'b0101);

      // saturation of the side planes
      do_clear(1, 250, 20);
      set_lane(0, 1, 7, 254); set_lane(1, 1, 8, 255); set_lane(2, 0, 0, 0); set_lane(3, 0, 0, 0);
      run_bundle("R4 saturate high");
      chk("R4 hi sat code", store[7], 1);
      do_clear(1, 5, 20);
      set_lane(0, 1, 7, 0); set_lane(1, 1, 8, 4); set_lane(2, 0, 0, 0); set_lane(3, 0, 0, 0);
      run_bundle("R4 saturate low");
      chk("R4 lo sat code", store[7], 2);

      // bypass
      do_clear(3, 10, 0);
      set_lane(0, 1, 1, 0); set_lane(1, 0, 1, 0); set_lane(2, 1, 2, 255); set_lane(3, 1, 2, 9);
      run_bundle("R9 bypass");
      chk("R9 bypass vld", out_vld, 4'b1101);
      chk("R9 bypass skip", out_skip, 0);

      // config inputs change mid-frame: ignored
      do_clear(0, 100, 0);
      cfg_mode = 2'd3; cfg_center = 8'd0;
      set_lane(0, 1, 20, 50); set_lane(1, 1, 20, 150); set_lane(2, 0, 0, 0); set_lane(3, 0, 0, 0);
      run_bundle("R8 cfg held");
      chk("R8 cfg held vld", out_vld, 4'b0001);

      // random traffic with frequent coordinate collisions
      for (int n = 0; n < 800; n++) begin
         if (n % 25 == 0) do_clear($urandom % 4, $urandom % 256, $urandom % 64);
         cfg_mode = 2'($urandom); cfg_center = ZW'($urandom);
         for (int i = 0; i < LANES; i++)
            set_lane(i, ($urandom % 4) != 0, $urandom % 6, $urandom % 256);
         run_bundle("random");
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule